// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for normal traffic. After reset it holds the bus at no-operation for a parameterized startup wait. This wait should cover at least 100 µs at the system clock rate. It then issues a precharge of every bank, followed by two auto-refresh commands spaced by the row-cycle time. Last, it issues a mode-register load. When the mode-register set delay has elapsed it raises a ready flag, and the surrounding controller then takes over the bus.

The word written into the mode register is computed at elaboration from three parameters: the burst length (1, 2, 4, 8, or 0 to mean a full page), the burst ordering (sequential or interleaved), and the CAS latency (2 or 3). Every gap between commands is a parameter expressed in clock cycles. All outputs are registered, so each pin changes one clock after the internal step that produces it.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset is released, the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) on every edge up to edge WAIT_CYCLES. The first non-NOP command appears at edge WAIT_CYCLES+1, counting rising edges from the first one sampled with reset low.
- R2: While reset is held, the pins show NOP, clock-enable is 1, address and bank are 0, and init_done is 0.
- R3: The first command is precharge-all, encoded cs_n=0, ras_n=0, cas_n=1, we_n=0, with the top address bit (bit ADDR_W-1, the auto-precharge position) at 1 and bank 0.
- R4: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1) appears exactly T_RP edges after the precharge.
- R5: The second auto-refresh appears exactly T_RC edges after the first. The mode-register load appears exactly T_RC edges after the second.
- R6: The mode-register load is encoded with all four command pins at 0 and bank 0, and it carries the mode word on the address pins.
- R7: Mode word bits [2:0] hold the burst-length code: 000 for 1, 001 for 2, 010 for 4, 011 for 8, and 111 for full page.
- R8: Mode word bit 3 is the burst ordering (0 for sequential, 1 for interleaved). Bits [6:4] hold the CAS latency as a binary number. All higher bits are 0.
- R9: init_done rises exactly T_MRD edges after the mode-register load. It then stays at 1, with the pins at NOP, until reset.
- R10: Clock-enable is 1 on every cycle.
- R11: Each of the four commands is driven for exactly one cycle, and the pins carry NOP between commands.
- R12: A reset asserted partway through the sequence returns all outputs to their reset state. After release, the whole sequence restarts from the beginning of the startup wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus, which carries the auto-precharge flag or the mode word |
| sd_ba | output | BANK_W | Bank select |
| init_done | output | 1 | High once the memory is ready for the main controller |

## Verification
Two events can coincide in one clock cycle: the ready flag rising and the last command leaving the bus. A sequencer that marked itself ready when it issued the load, rather than after the set delay, would hand the bus over while the mode register is still settling. The bench records the edge on which every non-NOP command appears and the edge on which init_done rises. It requires their distance to be exactly T_MRD, and it requires the pins to stay at NOP on every cycle while the flag is high. A second case is a reset that arrives in the middle of the refresh spacing: the bench judges it by checking that the outputs are cleared at once and that the next precharge waits out the full startup period again.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_PRE,
    ST_GAP_RP,
    ST_REF1,
    ST_GAP_RC1,
    ST_REF2,
    ST_GAP_RC2,
    ST_LMR,
    ST_GAP_MRD,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } sdram_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP = 4'b0111;
  localparam cmd_pins_t PINS_PRE = 4'b0010;
  localparam cmd_pins_t PINS_REF = 4'b0001;
  localparam cmd_pins_t PINS_LMR = 4'b0000;

  function automatic cmd_pins_t pins_of(input sdram_cmd_e c);
    case (c)
      CMD_PRE: pins_of = PINS_PRE;
      CMD_REF: pins_of = PINS_REF;
      CMD_LMR: pins_of = PINS_LMR;
      default: pins_of = PINS_NOP;
    endcase
  endfunction

  // A burst length of 0 selects a full page.
  function automatic logic [2:0] burst_code(input int bl);
    case (bl)
      1:       burst_code = 3'b000;
      2:       burst_code = 3'b001;
      4:       burst_code = 3'b010;
      8:       burst_code = 3'b011;
      default: burst_code = 3'b111;
    endcase
  endfunction

  function automatic logic [15:0] mode_word(input int bl, input bit interleave, input int cl);
    logic [15:0] w;
    w        = '0;
    w[2:0]   = burst_code(bl);
    w[3]     = interleave;
    w[6:4]   = cl[2:0];
    mode_word = w;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= RST_VAL;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_RP  = 3,
  parameter int T_RC  = 7,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output sdram_cmd_e       cmd,
  output logic             seq_done
);

  // A gap state lasts (spacing-1) cycles, so commands sit exactly 'spacing' apart.
  localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] GAP_RC  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 2);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_WAIT:    if (tmr_expired) state_d = ST_PRE;
      ST_PRE:     begin state_d = ST_GAP_RP;  tmr_load = 1'b1; tmr_val = GAP_RP;  end
      ST_GAP_RP:  if (tmr_expired) state_d = ST_REF1;
      ST_REF1:    begin state_d = ST_GAP_RC1; tmr_load = 1'b1; tmr_val = GAP_RC;  end
      ST_GAP_RC1: if (tmr_expired) state_d = ST_REF2;
      ST_REF2:    begin state_d = ST_GAP_RC2; tmr_load = 1'b1; tmr_val = GAP_RC;  end
      ST_GAP_RC2: if (tmr_expired) state_d = ST_LMR;
      ST_LMR:     begin state_d = ST_GAP_MRD; tmr_load = 1'b1; tmr_val = GAP_MRD; end
      ST_GAP_MRD: if (tmr_expired) state_d = ST_DONE;
      default:    state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WAIT;
    else     state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:           cmd = CMD_PRE;
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_LMR:           cmd = CMD_LMR;
      default:          cmd = CMD_NOP;
    endcase
  end

  assign seq_done = (state_q == ST_DONE);

  AST_PRE_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRE) |-> ($past(state_q) == ST_WAIT)); // R1
  AST_REF1_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REF1) |-> ($past(state_q) == ST_GAP_RP)); // R4
  AST_LMR_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LMR) |-> ($past(state_q) == ST_GAP_RC2)); // R5

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] MODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  sdram_cmd_e        cmd,
  input  logic              seq_done,
  output logic              cke,
  output cmd_pins_t         pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              done
);

  localparam int AP_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    if (cmd == CMD_PRE) addr_d[AP_BIT] = 1'b1;
    if (cmd == CMD_LMR) addr_d = MODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke  <= 1'b1;
      pins <= PINS_NOP;
      addr <= '0;
      ba   <= '0;
      done <= 1'b0;
    end else begin
      cke  <= 1'b1;
      pins <= pins_of(cmd);
      addr <= addr_d;
      ba   <= '0;
      done <= seq_done;
    end
  end

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pins != PINS_NOP) |=> (pins == PINS_NOP)); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (pins == PINS_NOP)); // R9
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (pins == PINS_PRE) |-> addr[AP_BIT]); // R3

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int BANK_W      = 2,
  parameter int WAIT_CYCLES = 5000,
  parameter int T_RP        = 3,
  parameter int T_RC        = 7,
  parameter int T_MRD       = 2,
  parameter int BURST_LEN   = 8,
  parameter bit BURST_ILV   = 1'b0,
  parameter int CAS_LAT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);

  localparam int MAX_A = (WAIT_CYCLES > T_RC) ? WAIT_CYCLES : T_RC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_V + 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [15:0] MODE_FULL = mode_word(BURST_LEN, BURST_ILV, CAS_LAT);
  localparam logic [ADDR_W-1:0] MODE = MODE_FULL[ADDR_W-1:0];

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  sdram_cmd_e       cmd;
  logic             seq_done;
  cmd_pins_t        pins;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_LOAD)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cmd         (cmd),
    .seq_done    (seq_done)
  );

  sdram_cmd_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MODE(MODE)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .seq_done (seq_done),
    .cke      (sd_cke),
    .pins     (pins),
    .addr     (sd_addr),
    .ba       (sd_ba),
    .done     (init_done)
  );

  assign sd_cs_n  = pins.cs_n;
  assign sd_ras_n = pins.ras_n;
  assign sd_cas_n = pins.cas_n;
  assign sd_we_n  = pins.we_n;

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb_top;

  localparam int W    = 20;
  localparam int TRP  = 3;
  localparam int TRC  = 7;
  localparam int TMRD = 2;
  localparam int AW   = 11;

  // Expected timeline: edge, pins {cs,ras,cas,we}, address, address mask.
  localparam int          EXP_EDGE [4] = '{W+1, W+1+TRP, W+1+TRP+TRC, W+1+TRP+2*TRC};
  localparam logic [3:0]  EXP_PINS [4] = '{4'b0010, 4'b0001, 4'b0001, 4'b0000};
  localparam logic [10:0] EXP_ADDR [4] = '{11'h400, 11'h000, 11'h000, 11'h033};
  localparam logic [10:0] EXP_MASK [4] = '{11'h400, 11'h000, 11'h000, 11'h7FF};
  localparam string       EXP_REQ  [4] = '{"R3", "R4", "R5", "R6"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cke, cs_n, ras_n, cas_n, we_n, done;
  logic [AW-1:0] addr;
  logic [1:0]    ba;
  logic          b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done;
  logic [AW-1:0] b_addr;
  logic [1:0]    b_ba;

  sdram_pwrup_seq #(.WAIT_CYCLES(W), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
    .BURST_LEN(8), .BURST_ILV(1'b0), .CAS_LAT(3)) dut_i (
    .clk(clk), .rst(rst), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr), .sd_ba(ba), .init_done(done));

  sdram_pwrup_seq #(.WAIT_CYCLES(W), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
    .BURST_LEN(0), .BURST_ILV(1'b1), .CAS_LAT(2)) dut_b (
    .clk(clk), .rst(rst), .sd_cke(b_cke), .sd_cs_n(b_cs_n), .sd_ras_n(b_ras_n),
    .sd_cas_n(b_cas_n), .sd_we_n(b_we_n), .sd_addr(b_addr), .sd_ba(b_ba), .init_done(b_done));

  int n_chk  = 0;
  int n_fail = 0;
  int n, log_n, done_edge, cke_bad;
  int log_edge [8];
  logic [3:0]    log_pins [8];
  logic [AW-1:0] log_addr [8];
  logic [1:0]    log_ba   [8];
  logic [AW-1:0] b_lmr;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    n = 0; log_n = 0; done_edge = -1; cke_bad = 0; b_lmr = '0;
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      n++;
      if (!cke || !b_cke) cke_bad++;
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (log_n < 8) begin
          log_edge[log_n] = n;
          log_pins[log_n] = {cs_n, ras_n, cas_n, we_n};
          log_addr[log_n] = addr;
          log_ba[log_n]   = ba;
        end
        log_n++;
      end
      if (done && done_edge < 0) done_edge = n;
      if ({b_cs_n, b_ras_n, b_cas_n, b_we_n} == 4'b0000) b_lmr = b_addr;
    end
  endtask

  task automatic chk_reset_state(input string req);
    chk(req, "pins", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(req, "cke", int'(cke), 1);
    chk(req, "addr", int'(addr), 0);
    chk(req, "ba", int'(ba), 0);
    chk(req, "init_done", int'(done), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    chk_reset_state("R2");
    rst = 1'b0;
    step(80);

    // Table walk over the four commands.
    chk("R11", "command count", log_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk(EXP_REQ[i], "edge", log_edge[i], EXP_EDGE[i]);
      chk(EXP_REQ[i], "pins", int'(log_pins[i]), int'(EXP_PINS[i]));
      chk(EXP_REQ[i], "addr", int'(log_addr[i] & EXP_MASK[i]), int'(EXP_ADDR[i]));
      chk(EXP_REQ[i], "bank", int'(log_ba[i]), 0);
    end
    chk("R1", "first command edge", log_edge[0], W + 1);
    chk("R9", "done edge", done_edge, EXP_EDGE[3] + TMRD);
    chk("R9", "done held", int'(done), 1);
    chk("R9", "pins quiet after done", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk("R10", "cke low cycles", cke_bad, 0);
    chk("R7", "full page code", int'(b_lmr[2:0]), 7);
    chk("R8", "interleave bit", int'(b_lmr[3]), 1);
    chk("R8", "cas field", int'(b_lmr[6:4]), 2);
    chk("R8", "upper zeros", int'(b_lmr[AW-1:7]), 0);

    // Reset after done clears the flag.
    rst = 1'b1;
    step(1);
    chk_reset_state("R12");

    // Restart, then reset between the refreshes.
    rst = 1'b0;
    clear_log();
    step(W + 1 + TRP + 2);
    chk("R12", "commands before abort", log_n, 2);
    chk("R12", "restart first edge", log_edge[0], W + 1);
    rst = 1'b1;
    clear_log();
    step(1);
    chk_reset_state("R12");
    rst = 1'b0;
    clear_log();
    step(80);
    chk("R12", "commands after restart", log_n, 4);
    chk("R12", "precharge edge after restart", log_edge[0], W + 1);
    chk("R12", "done after restart", done_edge, W + 1 + TRP + 2 * TRC + TMRD);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule